// File: doc/BRIEF.md
# Sampled Audio Replay DMA Engine

This block plays back a region of memory as audio. Software programs a frame start address and a frame end address, chooses stereo or mono and one of four fixed sample rates, and sets an enable bit. The engine then reads the frame one 16-bit word at a time over a request/acknowledge memory port. It splits each word into signed 8-bit samples and presents them on a left and a right output. A one-cycle strobe marks every newly presented sample.

When the fetch pointer reaches the end address, the engine either wraps back to the start address without a gap (loop set) or finishes the frame and stops (loop clear). When it stops it clears its own enable bit and drives both outputs to zero. The engine pulses an interrupt for every completed frame. Software can read the live fetch address at any time through the byte-wide register port.

Top module: `pcm_replay_dma`

## Requirements
- R1: The register port has the following byte addresses. 0 is control and 1 is mode. 2, 3 and 4 are the start address high, mid and low bytes. 5, 6 and 7 are the end address high, mid and low bytes. 8, 9 and 10 are the live address high, mid and low bytes. Reads are combinational. Writes to 8..10 are ignored, and other addresses read 0. Bit 0 of both low address bytes is stored and read as 0.
- R2: Control bit 0 is the enable and control bit 1 is the loop bit, and both read back in those positions. Writing the enable as 1 while it is 0 loads the live address from the start address.
- R3: mem_req, once raised, stays high with a stable, even mem_addr until mem_ack. mem_rdata is taken in the acknowledge cycle. Each accepted word advances the live address by 2. No request is issued while the live address equals the end address.
- R4: Mode bits 1:0 select the rate, with codes 00, 01, 10 and 11 giving 6258, 12517, 25033 and 50066 Hz. While data is available, strobes are spaced exactly round(CLK_HZ/rate) cycles apart.
- R5: With mode bit 7 at 0 (stereo), each strobe presents one word: the high byte on left_out and the low byte on right_out.
- R6: With mode bit 7 at 1 (mono), each word gives two strobes, the high byte first and then the low byte, and each sample appears on both outputs.
- R7: With loop set, the live address reloads the start address when it reaches the end address, and samples continue from the start of the frame at the same rate.
- R8: With loop clear, the engine handles the end of the frame as follows. At the first rate tick after the last sample of the frame, the enable clears and both outputs go to 0. The live address then reads as the end address.
- R9: frame_irq is a single-cycle pulse, given once each time the word that completes the frame is accepted.
- R10: While the enable is 0, both outputs are 0 from the next cycle on and no strobe is given. A request already in flight completes, and its data is discarded.
- R11: If the start address equals the end address and loop is clear, the engine issues no memory request and stops at the first rate tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 24 | Byte address of requested word (even) |
| mem_ack | input | 1 | Memory acknowledge, data valid |
| mem_rdata | input | 16 | Memory read word |
| left_out | output | 8 | Left sample, signed |
| right_out | output | 8 | Right sample, signed |
| sample_strobe | output | 1 | New sample present on outputs |
| frame_irq | output | 1 | End-of-frame pulse |

## Verification
The assertions check the memory handshake on every cycle: the request is held with a stable, even address until the acknowledge, and no request is issued at the end address. On every cycle they also check that the interrupt lasts a single cycle, that the outputs are zero and no strobe is given while disabled, and that left equals right for every mono strobe. Only the bench scenarios can show the sample order and byte-to-channel mapping, the spacing between strobes for each rate code, the seamless wrap in loop mode, and the self-clearing stop with its final live address. They also show the empty-frame case and the masking of address bit 0.

// File: rtl/pcm_replay_pkg.sv
package pcm_replay_pkg;
  localparam int unsigned ADDR_W    = 24;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned SAMP_W    = 8;
  localparam int unsigned NUM_RATES = 4;
  localparam int unsigned RATE_W    = $clog2(NUM_RATES);

  localparam logic [3:0] RA_CTRL    = 4'd0;
  localparam logic [3:0] RA_MODE    = 4'd1;
  localparam logic [3:0] RA_START_H = 4'd2;
  localparam logic [3:0] RA_START_M = 4'd3;
  localparam logic [3:0] RA_START_L = 4'd4;
  localparam logic [3:0] RA_END_H   = 4'd5;
  localparam logic [3:0] RA_END_M   = 4'd6;
  localparam logic [3:0] RA_END_L   = 4'd7;
  localparam logic [3:0] RA_LIVE_H  = 4'd8;
  localparam logic [3:0] RA_LIVE_M  = 4'd9;
  localparam logic [3:0] RA_LIVE_L  = 4'd10;

  // sample rate in Hz selected by each rate code
  function automatic int unsigned rate_hz(input int unsigned code);
    case (code)
      0:       return 6258;
      1:       return 12517;
      2:       return 25033;
      default: return 50066;
    endcase
  endfunction

  // clock cycles per sample, rounded to nearest
  function automatic int unsigned rate_div(input int unsigned clk_hz, input int unsigned code);
    return (clk_hz + rate_hz(code) / 2) / rate_hz(code);
  endfunction
endpackage

// File: rtl/pcm_rate_ticker.sv
module pcm_rate_ticker #(
  parameter int unsigned CLK_HZ = 125_000_000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              run,
  input  logic [pcm_replay_pkg::RATE_W-1:0] rate,
  output logic                              tick
);
  import pcm_replay_pkg::*;

  localparam int unsigned SLOW_DIV = rate_div(CLK_HZ, 0);
  localparam int unsigned DIV_W    = $clog2(SLOW_DIV + 1);

  logic [DIV_W-1:0] div_tab [NUM_RATES];
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_div
    localparam int unsigned DIV_G = rate_div(CLK_HZ, g);
    assign div_tab[g] = DIV_W'(DIV_G - 1);
  end

  assign limit = div_tab[rate];
  assign tick  = run && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pcm_word_fetch.sv
module pcm_word_fetch #(
  parameter int unsigned AW = 24,
  parameter int unsigned WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          load,
  input  logic          loop_en,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  input  logic          consume,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [WW-1:0] mem_rdata,
  output logic [WW-1:0] word,
  output logic          word_valid,
  output logic [AW-1:0] live_addr,
  output logic          frame_end,
  output logic          end_idle
);
  localparam logic [AW-1:0] STEP = AW'(WW / 8);

  logic          stale;
  logic          issue;
  logic          accept;
  logic [AW-1:0] next_addr;

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] a);
    return a + STEP;
  endfunction

  assign next_addr = advance(live_addr);
  assign issue     = run && !load && !mem_req && !word_valid && (live_addr != end_addr);
  assign accept    = mem_req && mem_ack && !stale && run && !load;
  assign end_idle  = (live_addr == end_addr) && !mem_req && !word_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      word       <= '0;
      word_valid <= 1'b0;
      live_addr  <= '0;
      frame_end  <= 1'b0;
      stale      <= 1'b0;
    end else begin
      frame_end <= 1'b0;
      if (issue) begin
        mem_req  <= 1'b1;
        mem_addr <= live_addr;
      end
      if (mem_req && mem_ack) begin
        mem_req <= 1'b0;
        stale   <= 1'b0;
      end
      if (accept) begin
        word       <= mem_rdata;
        word_valid <= 1'b1;
        if (next_addr == end_addr) begin
          frame_end <= 1'b1;
          live_addr <= loop_en ? start_addr : next_addr;
        end else begin
          live_addr <= next_addr;
        end
      end
      if (consume) word_valid <= 1'b0;
      if ((load || !run) && mem_req && !mem_ack) stale <= 1'b1;
      if (load) begin
        live_addr  <= start_addr;
        word_valid <= 1'b0;
      end
      if (!run) word_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_sample_unpack.sv
module pcm_sample_unpack #(
  parameter int unsigned WW = 16,
  parameter int unsigned SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          mono,
  input  logic          loop_en,
  input  logic [WW-1:0] word,
  input  logic          word_valid,
  input  logic          end_idle,
  output logic [SW-1:0] left_out,
  output logic [SW-1:0] right_out,
  output logic          sample_strobe,
  output logic          consume,
  output logic          stop
);
  logic          phase;
  logic [SW-1:0] hi_byte;
  logic [SW-1:0] lo_byte;
  logic [SW-1:0] mono_byte;

  assign hi_byte   = word[WW-1 -: SW];
  assign lo_byte   = word[SW-1:0];
  assign mono_byte = phase ? lo_byte : hi_byte;
  assign consume   = tick && run && word_valid && (!mono || phase);
  assign stop      = tick && run && !word_valid && end_idle && !loop_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_out      <= '0;
      right_out     <= '0;
      sample_strobe <= 1'b0;
      phase         <= 1'b0;
    end else begin
      sample_strobe <= 1'b0;
      if (!run) begin
        left_out  <= '0;
        right_out <= '0;
        phase     <= 1'b0;
      end else if (tick) begin
        if (word_valid) begin
          sample_strobe <= 1'b1;
          if (mono) begin
            left_out  <= mono_byte;
            right_out <= mono_byte;
            phase     <= !phase;
          end else begin
            left_out  <= hi_byte;
            right_out <= lo_byte;
            phase     <= 1'b0;
          end
        end else if (stop) begin
          left_out  <= '0;
          right_out <= '0;
          phase     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_replay_dma.sv
module pcm_replay_dma #(
  parameter int unsigned CLK_HZ = 125_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        mem_req,
  output logic [23:0] mem_addr,
  input  logic        mem_ack,
  input  logic [15:0] mem_rdata,
  output logic [7:0]  left_out,
  output logic [7:0]  right_out,
  output logic        sample_strobe,
  output logic        frame_irq
);
  import pcm_replay_pkg::*;

  logic              ctrl_en;
  logic              ctrl_loop;
  logic              mode_mono;
  logic [RATE_W-1:0] mode_rate;
  logic [ADDR_W-1:0] start_addr;
  logic [ADDR_W-1:0] end_addr;
  logic [ADDR_W-1:0] live_addr;
  logic              load_pulse;
  logic              tick;
  logic              consume;
  logic              stop_req;
  logic [WORD_W-1:0] word;
  logic              word_valid;
  logic              end_idle;

  assign load_pulse = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[0] && !ctrl_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en    <= 1'b0;
      ctrl_loop  <= 1'b0;
      mode_mono  <= 1'b0;
      mode_rate  <= '0;
      start_addr <= '0;
      end_addr   <= '0;
    end else begin
      if (stop_req) ctrl_en <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          RA_CTRL: begin
            ctrl_en   <= reg_wdata[0];
            ctrl_loop <= reg_wdata[1];
          end
          RA_MODE: begin
            mode_mono <= reg_wdata[7];
            mode_rate <= reg_wdata[RATE_W-1:0];
          end
          RA_START_H: start_addr[23:16] <= reg_wdata;
          RA_START_M: start_addr[15:8]  <= reg_wdata;
          RA_START_L: start_addr[7:0]   <= {reg_wdata[7:1], 1'b0};
          RA_END_H:   end_addr[23:16]   <= reg_wdata;
          RA_END_M:   end_addr[15:8]    <= reg_wdata;
          RA_END_L:   end_addr[7:0]     <= {reg_wdata[7:1], 1'b0};
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL:    reg_rdata = {6'b0, ctrl_loop, ctrl_en};
      RA_MODE:    reg_rdata = {mode_mono, {(8 - 1 - RATE_W){1'b0}}, mode_rate};
      RA_START_H: reg_rdata = start_addr[23:16];
      RA_START_M: reg_rdata = start_addr[15:8];
      RA_START_L: reg_rdata = start_addr[7:0];
      RA_END_H:   reg_rdata = end_addr[23:16];
      RA_END_M:   reg_rdata = end_addr[15:8];
      RA_END_L:   reg_rdata = end_addr[7:0];
      RA_LIVE_H:  reg_rdata = live_addr[23:16];
      RA_LIVE_M:  reg_rdata = live_addr[15:8];
      RA_LIVE_L:  reg_rdata = live_addr[7:0];
      default:    reg_rdata = 8'h00;
    endcase
  end

  pcm_rate_ticker #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ctrl_en),
    .rate  (mode_rate),
    .tick  (tick)
  );

  pcm_word_fetch #(.AW(ADDR_W), .WW(WORD_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctrl_en),
    .load       (load_pulse),
    .loop_en    (ctrl_loop),
    .start_addr (start_addr),
    .end_addr   (end_addr),
    .consume    (consume),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .word       (word),
    .word_valid (word_valid),
    .live_addr  (live_addr),
    .frame_end  (frame_irq),
    .end_idle   (end_idle)
  );

  pcm_sample_unpack #(.WW(WORD_W), .SW(SAMP_W)) u_unpack (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .run           (ctrl_en),
    .mono          (mode_mono),
    .loop_en       (ctrl_loop),
    .word          (word),
    .word_valid    (word_valid),
    .end_idle      (end_idle),
    .left_out      (left_out),
    .right_out     (right_out),
    .sample_strobe (sample_strobe),
    .consume       (consume),
    .stop          (stop_req)
  );
endmodule

// File: rtl/pcm_replay_dma_checks.sv
module pcm_replay_dma_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [23:0] mem_addr,
  input logic [23:0] end_addr,
  input logic        frame_irq,
  input logic        run,
  input logic        mono,
  input logic [7:0]  left_out,
  input logic [7:0]  right_out,
  input logic        sample_strobe
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R3
  AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]); // R3
  AST_NO_FETCH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> mem_addr != $past(end_addr)); // R3
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> !frame_irq); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> left_out == 8'h00 && right_out == 8'h00); // R10
  AST_STROBE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> $past(run)); // R10
  AST_MONO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe && $past(mono) |-> left_out == right_out); // R6
endmodule

bind pcm_replay_dma pcm_replay_dma_checks u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req       (mem_req),
  .mem_ack       (mem_ack),
  .mem_addr      (mem_addr),
  .end_addr      (end_addr),
  .frame_irq     (frame_irq),
  .run           (ctrl_en),
  .mono          (mode_mono),
  .left_out      (left_out),
  .right_out     (right_out),
  .sample_strobe (sample_strobe)
);

// File: tb/pcm_replay_dma_bench.sv
`timescale 1ns/1ps
module pcm_replay_dma_bench;
  localparam int NSC = 5;
  // scenario table: mono, rate code, loop, start, end
  localparam int SC_MONO  [NSC] = '{0, 1, 0, 1, 0};
  localparam int SC_RATE  [NSC] = '{0, 3, 2, 1, 3};
  localparam int SC_LOOP  [NSC] = '{0, 0, 1, 1, 0};
  localparam int SC_START [NSC] = '{'h010000, 'h0200F0, 'h003000, 'h00FFFC, 'h001235};
  localparam int SC_END   [NSC] = '{'h01000C, 'h020100, 'h003006, 'h010000, 'h00123D};
  // cycles per sample at 1 MHz for 6258/12517/25033/50066 Hz
  localparam int DIVS [4] = '{160, 80, 40, 20};

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [3:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_ack = 0;
  logic [15:0] mem_rdata = 0;
  logic [7:0]  left_out, right_out;
  logic        sample_strobe, frame_irq;

  int total = 0, bad = 0, cyc = 0, irq_cnt = 0, req_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pcm_replay_dma #(.CLK_HZ(1_000_000)) u_pcm_replay_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .left_out(left_out), .right_out(right_out),
    .sample_strobe(sample_strobe), .frame_irq(frame_irq)
  );

  function automatic logic [7:0] bytev(input logic [23:0] a);
    return a[7:0] * 8'd37 + a[15:8] + a[23:16] + 8'h5A;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (frame_irq) irq_cnt <= irq_cnt + 1;
    if (mem_req && mem_ack) req_cnt <= req_cnt + 1;
  end

  // memory model: acknowledge after two cycles
  initial begin : mem_model
    int lat;
    lat = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        lat++;
        if (lat == 2) begin
          mem_ack = 1;
          mem_rdata = {bytev(mem_addr), bytev(mem_addr + 24'd1)};
          lat = 0;
        end
      end else lat = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run_case(input int idx);
    int s, e, nwords, per_frame, want, got, last, dv, irq0, k, a;
    logic [7:0] d, el, er;
    bit mono, loop;
    mono = SC_MONO[idx] != 0;
    loop = SC_LOOP[idx] != 0;
    dv = DIVS[SC_RATE[idx]];
    s = SC_START[idx] & ~1;
    e = SC_END[idx] & ~1;
    nwords = (e - s) / 2;
    per_frame = mono ? 2 * nwords : nwords;
    want = loop ? 2 * per_frame : per_frame;

    wr(4'd1, {mono, 5'b0, 2'(SC_RATE[idx])});
    wr(4'd2, 8'(SC_START[idx] >> 16)); wr(4'd3, 8'(SC_START[idx] >> 8)); wr(4'd4, 8'(SC_START[idx]));
    wr(4'd5, 8'(SC_END[idx] >> 16));   wr(4'd6, 8'(SC_END[idx] >> 8));   wr(4'd7, 8'(SC_END[idx]));
    rd(4'd4, d);
    chk(d == 8'(s), "R1 start low byte bit0 masked", d, 8'(s));
    irq0 = irq_cnt;
    wr(4'd0, {6'b0, loop, 1'b1});
    rd(4'd10, d);
    chk(d == 8'(s), "R2 live address loaded from start", d, 8'(s));
    rd(4'd0, d);
    chk(d == {6'b0, loop, 1'b1}, "R2 control readback", d, {6'b0, loop, 1'b1});

    got = 0; last = 0;
    for (int t = 0; t < (want + 4) * dv && got < want; t++) begin
      @(negedge clk);
      if (sample_strobe) begin
        k = got % per_frame;
        if (mono) begin
          a = s + k; el = bytev(24'(a)); er = el;
        end else begin
          a = s + 2 * k; el = bytev(24'(a)); er = bytev(24'(a + 1));
        end
        if (got >= per_frame) begin
          chk(left_out == el && right_out == er, "R7 wrapped sample", {left_out, right_out}, {el, er});
        end else if (mono) begin
          chk(left_out == el && right_out == er, "R6 mono sample", {left_out, right_out}, {el, er});
        end else begin
          chk(left_out == el && right_out == er, "R5 stereo sample", {left_out, right_out}, {el, er});
        end
        if (got > 0) chk(cyc - last == dv, "R4 strobe spacing", cyc - last, dv);
        last = cyc;
        got++;
      end
    end
    chk(got == want, "R4 sample count", got, want);

    if (!loop) begin
      d = 8'h01;
      for (int t = 0; t < 3 * dv + 8 && d[0]; t++) rd(4'd0, d);
      chk(d[0] == 1'b0, "R8 enable self-cleared", d, 0);
      chk(left_out == 0 && right_out == 0, "R8 outputs zero", {left_out, right_out}, 0);
      rd(4'd8, d);  chk(d == 8'(e >> 16), "R8 live addr high", d, 8'(e >> 16));
      rd(4'd9, d);  chk(d == 8'(e >> 8),  "R8 live addr mid",  d, 8'(e >> 8));
      rd(4'd10, d); chk(d == 8'(e),       "R8 live addr low",  d, 8'(e));
      chk(irq_cnt - irq0 == 1, "R9 one irq per frame", irq_cnt - irq0, 1);
    end else begin
      chk(irq_cnt - irq0 == 2, "R9 irq per looped frame", irq_cnt - irq0, 2);
      wr(4'd0, 8'h00);
      @(negedge clk);
      chk(left_out == 0 && right_out == 0, "R10 outputs zero after disable", {left_out, right_out}, 0);
      repeat (8) @(negedge clk);
      chk(sample_strobe == 0, "R10 no strobe while disabled", sample_strobe, 0);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    int r0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    rd(4'd0, d);
    chk(d == 0, "R2 control after reset", d, 0);
    chk(left_out == 0 && right_out == 0 && !mem_req && !sample_strobe,
        "R10 outputs idle after reset", {left_out, right_out, 7'b0, mem_req}, 0);
    // live address is read-only, unused address reads 0
    wr(4'd8, 8'hFF);
    rd(4'd8, d);
    chk(d == 0, "R1 live address write ignored", d, 0);
    wr(4'd12, 8'hA5);
    rd(4'd12, d);
    chk(d == 0, "R1 unmapped address reads zero", d, 0);
    wr(4'd1, 8'h83);
    rd(4'd1, d);
    chk(d == 8'h83, "R1 mode readback", d, 8'h83);

    // table-driven scenarios
    for (int i = 0; i < NSC; i++) run_case(i);

    // empty frame with loop clear
    wr(4'd1, 8'h03);
    wr(4'd2, 8'h00); wr(4'd3, 8'h04); wr(4'd4, 8'h00);
    wr(4'd5, 8'h00); wr(4'd6, 8'h04); wr(4'd7, 8'h00);
    r0 = req_cnt;
    wr(4'd0, 8'h01);
    repeat (3 * 20) @(negedge clk);
    rd(4'd0, d);
    chk(d[0] == 1'b0, "R11 empty frame stops", d, 0);
    chk(req_cnt == r0, "R11 no memory request", req_cnt - r0, 0);
    chk(left_out == 0 && right_out == 0, "R11 outputs zero", {left_out, right_out}, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule